// File: doc/BRIEF.md
# Addressable RGB LED Waveform Serializer

This block drives the single data wire of a chain of addressable RGB LED pixels. It pulls 24-bit pixel words from an upstream ready/valid source, puts the three colour bytes in the order the LED parts expect, and sends each bit as a high pulse followed by a low pulse. The length of each pulse depends on whether the bit is a one or a zero. Once the programmed number of pixels has gone out, the line is held low for a latch gap and a one-cycle completion event is raised.

Four cycle counts set the bit timing: high and low for a one, high and low for a zero. A further count sets the latch gap, a 3-bit code sets the channel order, and a 13-bit count sets the frame length. All of these come from configuration registers elsewhere in the chip. For example, a 0-bit of about 336 ns high and 840 ns low becomes a count of each duration divided by the clock period. A frame starts when the enable input is high, and dropping the enable abandons the frame at once.

Top module: `led_wave_ser`

## Requirements
- R1: A 1-bit is sent as `t1_hi` cycles high then `t1_lo` cycles low, and a 0-bit as `t0_hi` cycles high then `t0_lo` cycles low. A count of zero behaves as one cycle. `t1_hi` and `t0_lo` are 6 bits wide, `t1_lo` and `t0_hi` are 5 bits wide.
- R2: Each pixel is sent as 24 bits, with each transmitted byte most significant bit first. When the next word is already valid, consecutive pixels follow with no extra cycles between them.
- R3: Input word fields are first channel [23:16], second [15:8] and third [7:0], called r, g and b. `order_sel` codes 0 to 5 transmit rgb, rbg, grb, gbr, brg and bgr. Codes 6 and 7 transmit rgb.
- R4: A frame accepts exactly `frame_len` words. `pix_ready` stays low once that many words have been taken. With `frame_len` equal to 0, no frame starts.
- R5: After the last bit's low phase, the line stays low for a further `gap_len` cycles, with 0 behaving as 1. `frame_done` is then high for exactly one cycle, the cycle right after the gap.
- R6: While `enable` is low, `pix_ready` is low, and `led_out` is low from the next cycle on. A frame cut short this way raises no `frame_done`, and the next frame starts from its first pixel.
- R7: If no word is valid in the middle of a frame, the line stays low and the block waits. Transmission then resumes with the next word, and `frame_done` still comes only after all `frame_len` pixels.
- R8: During reset and between frames, `led_out`, `pix_ready` and `frame_done` are low.
- R9: If `enable` stays high after `frame_done`, a new frame begins and `pix_ready` rises within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Transmission enable |
| t1_hi | input | 6 | High cycles of a 1-bit |
| t1_lo | input | 5 | Low cycles of a 1-bit |
| t0_hi | input | 5 | High cycles of a 0-bit |
| t0_lo | input | 6 | Low cycles of a 0-bit |
| gap_len | input | 20 | Latch gap length in cycles |
| order_sel | input | 3 | Transmitted colour order code |
| frame_len | input | 13 | Pixels per frame |
| pix_data | input | 24 | Pixel word from the source |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Block takes the word this cycle |
| led_out | output | 1 | Serial line to the LED chain |
| frame_done | output | 1 | One-cycle pulse after the latch gap |

## Verification
The assertions check every cycle that a high pulse never outlasts the longer programmed high time, that no word is requested past the frame length, and that the completion pulse comes only after the exact word count, lasts one cycle, and sits on a low line. They also check that the handshake and the line go quiet when the enable drops. Only the bench scenarios can show the rest. Decoding the waveform back into pixels covers the exact pulse lengths, bit order and channel permutations, the back-to-back joining of pixels, the exact gap length, stalls in the middle of a frame, restart after an abort, and frame-to-frame repetition.

// File: rtl/led_ser_pkg.sv
`timescale 1ns/1ps
// Shared types for the LED waveform serializer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package led_ser_pkg;

    // Phase of the per-bit pulse generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HI   = 2'd1,
        PH_LO   = 2'd2
    } bit_phase_e;

    // Frame sequencer state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } frame_state_e;

    // Transmitted channel order codes
    typedef enum logic [2:0] {
        ORD_RGB = 3'd0,
        ORD_RBG = 3'd1,
        ORD_GRB = 3'd2,
        ORD_GBR = 3'd3,
        ORD_BRG = 3'd4,
        ORD_BGR = 3'd5
    } chan_order_e;

endpackage

// File: rtl/led_chan_order.sv
`timescale 1ns/1ps
// Permutes the three colour bytes of a pixel word into transmit order.
// Assumes: input fields are first/second/third channel from the top byte
// down; unknown codes fall back to the identity order.
module led_chan_order
    import led_ser_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [3*CH_W-1:0] pix_in,
    input  logic [2:0]        sel,
    output logic [3*CH_W-1:0] pix_out
);
    logic [CH_W-1:0] c_r, c_g, c_b;

    assign c_r = pix_in[3*CH_W-1:2*CH_W];
    assign c_g = pix_in[2*CH_W-1:CH_W];
    assign c_b = pix_in[CH_W-1:0];

    // Select the byte permutation for the current order code
    always_comb begin
        case (chan_order_e'(sel))
            ORD_RBG: pix_out = {c_r, c_b, c_g};
            ORD_GRB: pix_out = {c_g, c_r, c_b};
            ORD_GBR: pix_out = {c_g, c_b, c_r};
            ORD_BRG: pix_out = {c_b, c_r, c_g};
            ORD_BGR: pix_out = {c_b, c_g, c_r};
            default: pix_out = {c_r, c_g, c_b};
        endcase
    end
endmodule

// File: rtl/led_bit_engine.sv
`timescale 1ns/1ps
// Shifts one pixel out MSB first as high/low pulse pairs whose lengths
// depend on the bit value. A new word may be loaded when idle or in the
// last cycle of the final bit, giving gapless back-to-back pixels.
// Assumes: load is only asserted when busy is low or last is high.
module led_bit_engine
    import led_ser_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int T1H_W = 6,
    parameter int T1L_W = 5,
    parameter int T0H_W = 5,
    parameter int T0L_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               load,
    input  logic [3*CH_W-1:0]  data,
    input  logic [T1H_W-1:0]   t1_hi,
    input  logic [T1L_W-1:0]   t1_lo,
    input  logic [T0H_W-1:0]   t0_hi,
    input  logic [T0L_W-1:0]   t0_lo,
    output logic               busy,
    output logic               last,
    output logic               line
);
    localparam int PIX_W = 3 * CH_W;
    localparam int W_ONE = (T1H_W > T1L_W) ? T1H_W : T1L_W;
    localparam int W_ZER = (T0H_W > T0L_W) ? T0H_W : T0L_W;
    localparam int CNT_W = (W_ONE > W_ZER) ? W_ONE : W_ZER;
    localparam int BIT_W = $clog2(PIX_W);

    bit_phase_e        ph;
    logic [CNT_W-1:0]  cnt;
    logic [PIX_W-1:0]  sr;
    logic [BIT_W-1:0]  bits;
    logic [CNT_W-1:0]  d1h, d1l, d0h, d0l;
    logic [CNT_W-1:0]  hi_load, hi_next, lo_cur;

    // Reload values: programmed count minus one, zero behaving as one
    always_comb begin
        d1h = (t1_hi == '0) ? '0 : CNT_W'(t1_hi) - 1'b1;
        d1l = (t1_lo == '0) ? '0 : CNT_W'(t1_lo) - 1'b1;
        d0h = (t0_hi == '0) ? '0 : CNT_W'(t0_hi) - 1'b1;
        d0l = (t0_lo == '0) ? '0 : CNT_W'(t0_lo) - 1'b1;
        hi_load = data[PIX_W-1]  ? d1h : d0h;
        hi_next = sr[PIX_W-2]    ? d1h : d0h;
        lo_cur  = sr[PIX_W-1]    ? d1l : d0l;
    end

    assign busy = (ph != PH_IDLE);
    assign last = (ph == PH_LO) && (cnt == '0) && (bits == '0);

    // Pulse sequencer: high phase, low phase, next bit or next word
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            sr   <= '0;
            bits <= '0;
            line <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (load) begin
                        sr   <= data;
                        bits <= BIT_W'(PIX_W - 1);
                        cnt  <= hi_load;
                        ph   <= PH_HI;
                        line <= 1'b1;
                    end
                end
                PH_HI: begin
                    if (cnt == '0) begin
                        cnt  <= lo_cur;
                        ph   <= PH_LO;
                        line <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LO: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (bits != '0) begin
                        sr   <= {sr[PIX_W-2:0], 1'b0};
                        bits <= bits - 1'b1;
                        cnt  <= hi_next;
                        ph   <= PH_HI;
                        line <= 1'b1;
                    end else if (load) begin
                        sr   <= data;
                        bits <= BIT_W'(PIX_W - 1);
                        cnt  <= hi_load;
                        ph   <= PH_HI;
                        line <= 1'b1;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/led_gap_timer.sv
`timescale 1ns/1ps
// Counts the low latch gap that closes a frame.
// Assumes: start is a single-cycle strobe; a zero length behaves as one.
module led_gap_timer #(
    parameter int GAP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [GAP_W-1:0] len,
    output logic             fin
);
    logic             run;
    logic [GAP_W-1:0] cnt;

    assign fin = run && (cnt == '0);

    // Load on start, count down, stop after the final cycle
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= (len == '0) ? '0 : len - 1'b1;
        end else if (fin) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/led_wave_ser.sv
`timescale 1ns/1ps
// Top of the LED waveform serializer: frame sequencing around the channel
// permutation, the per-bit pulse engine and the latch gap timer.
// Assumes: configuration inputs are held steady while a frame runs.
module led_wave_ser
    import led_ser_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int T1H_W = 6,
    parameter int T1L_W = 5,
    parameter int T0H_W = 5,
    parameter int T0L_W = 6,
    parameter int GAP_W = 20,
    parameter int LEN_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [T1H_W-1:0]   t1_hi,
    input  logic [T1L_W-1:0]   t1_lo,
    input  logic [T0H_W-1:0]   t0_hi,
    input  logic [T0L_W-1:0]   t0_lo,
    input  logic [GAP_W-1:0]   gap_len,
    input  logic [2:0]         order_sel,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [3*CH_W-1:0]  pix_data,
    input  logic               pix_valid,
    output logic               pix_ready,
    output logic               led_out,
    output logic               frame_done
);
    localparam int PIX_W = 3 * CH_W;

    frame_state_e      st;
    logic [LEN_W-1:0]  left;
    logic [PIX_W-1:0]  pix_ord;
    logic              eng_busy, eng_last, gap_fin, hs, gap_start, abort;

    assign abort     = !enable;
    assign pix_ready = enable && (st == ST_RUN) && (left != '0) && (!eng_busy || eng_last);
    assign hs        = pix_ready && pix_valid;
    assign gap_start = enable && (st == ST_RUN) && eng_last && (left == '0);

    led_chan_order #(.CH_W(CH_W)) u_order (
        .pix_in (pix_data),
        .sel    (order_sel),
        .pix_out(pix_ord)
    );

    led_bit_engine #(
        .CH_W(CH_W), .T1H_W(T1H_W), .T1L_W(T1L_W), .T0H_W(T0H_W), .T0L_W(T0L_W)
    ) u_engine (
        .clk  (clk),
        .rst_n(rst_n),
        .abort(abort),
        .load (hs),
        .data (pix_ord),
        .t1_hi(t1_hi),
        .t1_lo(t1_lo),
        .t0_hi(t0_hi),
        .t0_lo(t0_lo),
        .busy (eng_busy),
        .last (eng_last),
        .line (led_out)
    );

    led_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .abort(abort),
        .start(gap_start),
        .len  (gap_len),
        .fin  (gap_fin)
    );

    // Frame sequencer: count words, hand over to the gap, pulse completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            left       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!enable) begin
                st   <= ST_IDLE;
                left <= '0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (frame_len != '0) begin
                            st   <= ST_RUN;
                            left <= frame_len;
                        end
                    end
                    ST_RUN: begin
                        if (hs)
                            left <= left - 1'b1;
                        else if (gap_start)
                            st <= ST_GAP;
                    end
                    ST_GAP: begin
                        if (gap_fin) begin
                            st         <= ST_IDLE;
                            frame_done <= 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/led_wave_ser_chk.sv
`timescale 1ns/1ps
// Protocol checker for led_wave_ser, attached by bind.
// Assumes: frame_len is steady during a frame.
module led_wave_ser_chk #(
    parameter int T1H_W = 6,
    parameter int T1L_W = 5,
    parameter int T0H_W = 5,
    parameter int T0L_W = 6,
    parameter int LEN_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [T1H_W-1:0] t1_hi,
    input logic [T0H_W-1:0] t0_hi,
    input logic [LEN_W-1:0] frame_len,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             led_out,
    input logic             frame_done
);
    localparam int HW = (T1H_W > T0H_W) ? T1H_W : T0H_W;

    logic [LEN_W:0] acc_n;
    logic [HW:0]    hi_run;
    logic [HW:0]    e1, e0, hmax;

    assign e1   = (t1_hi == '0) ? (HW+1)'(1) : (HW+1)'(t1_hi);
    assign e0   = (t0_hi == '0) ? (HW+1)'(1) : (HW+1)'(t0_hi);
    assign hmax = (e1 > e0) ? e1 : e0;

    // Words accepted in the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || frame_done) acc_n <= '0;
        else if (pix_ready && pix_valid)     acc_n <= acc_n + 1'b1;
    end

    // Length of the current high run, excluding this cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !led_out) hi_run <= '0;
        else                    hi_run <= hi_run + 1'b1;
    end

    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        led_out |-> hi_run < hmax); // R1
    AST_NO_EXTRA_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> acc_n < {1'b0, frame_len}); // R4
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> acc_n == {1'b0, frame_len}); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R5
    AST_DONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!led_out && !$past(led_out))); // R5
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> enable); // R6
    AST_LOW_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !led_out); // R6
endmodule

bind led_wave_ser led_wave_ser_chk #(
    .T1H_W(T1H_W), .T1L_W(T1L_W), .T0H_W(T0H_W), .T0L_W(T0L_W), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .t1_hi     (t1_hi),
    .t0_hi     (t0_hi),
    .frame_len (frame_len),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .led_out   (led_out),
    .frame_done(frame_done)
);

// File: tb/led_wave_ser_bench.sv
`timescale 1ns/1ps
// Self-checking bench: decodes the serial line back into pixels and
// compares with a model of the channel order, pulse and gap lengths.
module led_wave_ser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [5:0]  t1_hi = '0;
    logic [4:0]  t1_lo = '0;
    logic [4:0]  t0_hi = '0;
    logic [5:0]  t0_lo = '0;
    logic [19:0] gap_len = '0;
    logic [2:0]  order_sel = '0;
    logic [12:0] frame_len = '0;
    logic [23:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, led_out, frame_done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    led_wave_ser u_led_wave_ser (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .t1_hi(t1_hi), .t1_lo(t1_lo), .t0_hi(t0_hi), .t0_lo(t0_lo),
        .gap_len(gap_len), .order_sel(order_sel), .frame_len(frame_len),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .led_out(led_out), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [23:0] model_order(input logic [23:0] w, input int o);
        logic [7:0] r, g, b;
        r = w[23:16]; g = w[15:8]; b = w[7:0];
        case (o)
            1: return {r, b, g};
            2: return {g, r, b};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {r, g, b};
        endcase
    endfunction

    // Line decoder state
    bit          mon_on = 1'b0;
    bit          mon_stall = 1'b0;
    logic        prev = 1'b0;
    int          run = 0;
    int          nbits = 0;
    logic        last_bit = 1'b0;
    logic [23:0] shreg = '0;
    logic [23:0] cap [16];
    int          cap_n = 0;
    int          e1h, e1l, e0h, e0l, egap;

    task automatic mon_clear();
        prev = led_out; run = 0; nbits = 0; cap_n = 0; shreg = '0;
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (led_out != prev) begin
                if (prev) begin
                    chk(run == e1h || run == e0h, "R1", "high length", run, e1h);
                    last_bit = (run == e1h);
                    shreg = {shreg[22:0], last_bit};
                    nbits++;
                    if (nbits % 24 == 0 && cap_n < 16) begin
                        cap[cap_n] = shreg;
                        cap_n++;
                    end
                end else if (nbits > 0) begin
                    if (nbits % 24 != 0)
                        chk(run == (last_bit ? e1l : e0l), "R1", "low length", run, last_bit ? e1l : e0l);
                    else if (!mon_stall)
                        chk(run == (last_bit ? e1l : e0l), "R2", "pixel join low", run, last_bit ? e1l : e0l);
                end
                run = 1;
            end else begin
                run++;
            end
            if (frame_done)
                chk(run == (last_bit ? e1l : e0l) + egap + 1, "R5", "gap low length",
                    run, (last_bit ? e1l : e0l) + egap + 1);
            prev = led_out;
        end
    end

    task automatic set_cfg(input int a, input int b, input int c, input int d,
                           input int g, input int o, input int len);
        t1_hi = 6'(a); t1_lo = 5'(b); t0_hi = 5'(c); t0_lo = 6'(d);
        gap_len = 20'(g); order_sel = 3'(o); frame_len = 13'(len);
        e1h = eff(a); e1l = eff(b); e0h = eff(c); e0l = eff(d); egap = eff(g);
    endtask

    // Runs one frame and checks words taken and pixels decoded (R2 R3 R4 R5 R7)
    task automatic run_frame(input int a, input int b, input int c, input int d,
                             input int g, input int o, input int len, input bit stall);
        logic [23:0] words [16];
        int hs_n;
        bit got;
        for (int i = 0; i < 16; i++) words[i] = 24'($urandom);
        @(negedge clk);
        set_cfg(a, b, c, d, g, o, len);
        #1;
        mon_clear();
        mon_stall = stall;
        mon_on = 1'b1;
        enable = 1'b1;
        hs_n = 0;
        got = 1'b0;
        for (int cyc = 0; cyc < 20000 && !got; cyc++) begin
            @(negedge clk);
            #2;
            if (frame_done) begin
                got = 1'b1;
            end else begin
                pix_valid = stall ? (($urandom % 3) != 0) : 1'b1;
                pix_data  = words[hs_n % 16];
                #0.2;
                if (pix_ready && pix_valid) hs_n++;
            end
        end
        enable = 1'b0;
        pix_valid = 1'b0;
        chk(got, "R5", "frame_done seen", got, 1);
        chk(hs_n == len, stall ? "R7" : "R4", "words taken", hs_n, len);
        chk(cap_n == len, "R2", "pixels decoded", cap_n, len);
        for (int i = 0; i < len && i < cap_n; i++)
            chk(cap[i] == model_order(words[i], o), "R3", "pixel value", cap[i], model_order(words[i], o));
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    initial begin
        int a, b, c, d;
        void'($urandom(32'h5EED_1234));
        set_cfg(3, 2, 1, 3, 5, 2, 2);
        enable = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!led_out && !pix_ready && !frame_done, "R8", "outputs in reset",
                {led_out, pix_ready, frame_done}, 0);
        end
        @(negedge clk);
        enable = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!led_out && !pix_ready && !frame_done, "R8", "idle outputs",
            {led_out, pix_ready, frame_done}, 0);

        // Directed: usual order, no stall
        run_frame(6, 3, 2, 5, 10, 2, 3, 1'b0);
        // Directed: code 6 falls back to rgb, single pixel
        run_frame(4, 2, 1, 4, 3, 6, 1, 1'b0);
        // Directed: zero counts behave as one
        run_frame(3, 0, 0, 2, 0, 5, 2, 1'b0);
        // Directed: stalls mid-frame
        run_frame(5, 2, 2, 4, 7, 3, 4, 1'b1);

        // R4: zero frame length starts nothing
        @(negedge clk);
        set_cfg(4, 2, 1, 4, 3, 0, 0);
        enable = 1'b1; pix_valid = 1'b1;
        begin
            bit seen = 1'b0;
            repeat (40) begin
                @(negedge clk); #2;
                if (pix_ready || led_out || frame_done) seen = 1'b1;
            end
            chk(!seen, "R4", "zero length stays idle", seen, 0);
        end
        enable = 1'b0; pix_valid = 1'b0;

        // R6: abort mid-frame, then a full frame restarts from the first word
        @(negedge clk);
        set_cfg(4, 2, 1, 4, 3, 1, 4);
        pix_data = 24'hF0F0F0; pix_valid = 1'b1; enable = 1'b1;
        repeat (100) @(negedge clk);
        enable = 1'b0;
        #0.5;
        chk(!pix_ready, "R6", "ready drops with enable", pix_ready, 0);
        @(negedge clk);
        chk(!led_out, "R6", "line low after disable", led_out, 0);
        begin
            bit seen = 1'b0;
            repeat (40) begin
                @(negedge clk);
                if (frame_done || led_out) seen = 1'b1;
            end
            chk(!seen, "R6", "no done after abort", seen, 0);
        end
        pix_valid = 1'b0;
        run_frame(4, 2, 1, 4, 3, 1, 4, 1'b0);

        // R9: enable held after completion restarts a frame
        @(negedge clk);
        set_cfg(2, 1, 1, 2, 2, 0, 1);
        pix_data = 24'h123456; pix_valid = 1'b1; enable = 1'b1;
        begin
            bit got = 1'b0;
            for (int cyc = 0; cyc < 3000 && !got; cyc++) begin
                @(negedge clk); #2;
                if (frame_done) got = 1'b1;
            end
            pix_valid = 1'b0;
            chk(got, "R9", "first frame done", got, 1);
            @(negedge clk); @(negedge clk); #2;
            chk(pix_ready, "R9", "ready after restart", pix_ready, 1);
        end
        enable = 1'b0;
        repeat (5) @(negedge clk);

        // Random frames
        for (int k = 0; k < 10; k++) begin
            a = 1 + int'($urandom % 15);
            b = int'($urandom % 9);
            d = 1 + int'($urandom % 15);
            do c = int'($urandom % 9); while (eff(c) == a);
            run_frame(a, b, c, d, int'($urandom % 41), int'($urandom % 8),
                      1 + int'($urandom % 5), 1'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule